// File: doc/BRIEF.md
# Serial Media-Independent Receive Deserializer (MAC Side)

This block turns the single receive line of a serial media-independent link into bytes and line status for a MAC. A sync input, synchronous to the one reference clock, is high on the first bit of every 10-bit segment. The block collects each segment and reads its first bit as carrier sense and its second bit as the receive data valid flag. The remaining eight bits are either one data byte or an in-band status byte.

While data valid is high, the payload bits form a byte, least significant bit first. At 100 Mb/s every segment delivers a new byte. At 10 Mb/s the far end repeats each byte over ten segments. The block locks a ten-segment window to the segment where data valid first rises and takes only the first segment of each window. While data valid is low, the payload carries the line status. The block keeps the latest copy and accepts it only when the three trailing marker bits have their fixed values.

Top module: `smii_rx_deser`

## Requirements
- R1: A segment starts on the clock cycle where `sync_in` is high and covers that bit and the next nine bits of `rx_line`. Segment bit 1 (the sync bit) is carrier sense, and `carrier_sense` takes its value from every completed segment.
- R2: With `mode_fast` high, every segment whose bit 2 (data valid) is high produces one byte on `rx_byte`. Segment bit 3 is byte bit 0 and segment bit 10 is byte bit 7.
- R3: With `mode_fast` low, the first data-valid segment after a segment with data valid low is accepted. After that, only every tenth consecutive data-valid segment is accepted, and the bytes in the nine segments between are discarded.
- R4: `rx_byte_vld` is high for exactly one clock per accepted byte.
- R5: `rx_frame_end` pulses for one clock when a segment with data valid low follows a segment with data valid high. It never coincides with `rx_byte_vld`.
- R6: A segment with data valid low and bits 8, 9, 10 equal to 1, 0, 1 loads the status outputs from its payload: bit 3 receive error, bit 4 speed (1 = 100 Mb/s), bit 5 duplex (1 = full), bit 6 link (1 = up), bit 7 jabber.
- R7: Status outputs keep their value through data-valid segments and through segments whose trailing bits are not 1, 0, 1.
- R8: A synchronous active-high `rst` clears the segment tracking, the byte strobe, the frame-end strobe, carrier sense and all status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | High on the first bit of each segment |
| rx_line | input | 1 | Serial receive data |
| mode_fast | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| rx_byte | output | 8 | Last accepted data byte |
| rx_byte_vld | output | 1 | One-clock strobe for `rx_byte` |
| rx_frame_end | output | 1 | One-clock strobe when data valid falls |
| carrier_sense | output | 1 | Carrier sense from the latest segment |
| st_rx_err | output | 1 | Receive error from the latest status segment |
| st_speed_100 | output | 1 | Speed from the latest status segment |
| st_full_duplex | output | 1 | Duplex from the latest status segment |
| st_link_up | output | 1 | Link from the latest status segment |
| st_jabber | output | 1 | Jabber from the latest status segment |

## Verification
The bound checker watches the following on every cycle:
- the width of the byte and frame-end strobes, and that the two never coincide;
- that a data-valid segment at 100 Mb/s is followed by a byte;
- that, within a 10 Mb/s frame, two accepted bytes are at least ten segments apart;
- that status and carrier change only right after a completed segment;
- the cleared state after reset.

Only the bench scenarios can show that the right segment of each ten-segment window is taken, that bit order and status field positions are correct, and that a segment whose trailing bits do not match leaves the status alone. The bench shows the window choice by sending different byte values in the nine discarded repeats.

// File: rtl/smii_rx_pkg.sv
package smii_rx_pkg;
  localparam int SEG_LEN  = 10;
  localparam int BYTE_W   = 8;
  localparam int CRS_BIT  = 0;
  localparam int DV_BIT   = 1;
  localparam int PAY_LO   = 2;
  localparam int ST_W     = 5;
  // Trailing marker as {bit10, bit9, bit8} of a status segment.
  localparam logic [2:0] ST_MARK = 3'b101;

  typedef struct packed {
    logic jabber;
    logic link;
    logic duplex;
    logic speed;
    logic rx_err;
  } rx_status_t;
endpackage

// File: rtl/smii_rx_seg_capture.sv
module smii_rx_seg_capture #(
  parameter int SEG_LEN = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_in,
  input  logic               rx_line,
  output logic               seg_vld,
  output logic [SEG_LEN-1:0] seg_word
);
  localparam int CNT_W = $clog2(SEG_LEN);

  logic [CNT_W-1:0]   pos;
  logic               active;
  logic [SEG_LEN-2:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      active   <= 1'b0;
      hold     <= '0;
      seg_vld  <= 1'b0;
      seg_word <= '0;
    end else begin
      seg_vld <= 1'b0;
      if (sync_in) begin
        hold   <= {rx_line, hold[SEG_LEN-2:1]};
        pos    <= CNT_W'(1);
        active <= 1'b1;
      end else if (active) begin
        if (pos == CNT_W'(SEG_LEN-1)) begin
          seg_word <= {rx_line, hold};
          seg_vld  <= 1'b1;
          active   <= 1'b0;
          pos      <= '0;
        end else begin
          hold <= {rx_line, hold[SEG_LEN-2:1]};
          pos  <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/smii_rx_rate_gate.sv
module smii_rx_rate_gate #(
  parameter int REPEAT = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_vld,
  input  logic              seg_dv,
  input  logic [BYTE_W-1:0] payload,
  input  logic              mode_fast,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              frame_end
);
  localparam int PH_W = (REPEAT > 1) ? $clog2(REPEAT) : 1;

  logic            dv_prev;
  logic [PH_W-1:0] phase;
  logic            accept;

  always_comb begin
    accept = 1'b0;
    if (seg_vld && seg_dv)
      accept = mode_fast || (phase == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_prev   <= 1'b0;
      phase     <= '0;
      byte_out  <= '0;
      byte_vld  <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frame_end <= 1'b0;
      if (seg_vld) begin
        dv_prev   <= seg_dv;
        frame_end <= dv_prev && !seg_dv;
        if (!seg_dv)
          phase <= '0;
        else if (phase == PH_W'(REPEAT-1))
          phase <= '0;
        else
          phase <= phase + 1'b1;
        if (accept) begin
          byte_vld <= 1'b1;
          byte_out <= payload;
        end
      end
    end
  end
endmodule

// File: rtl/smii_rx_status_hold.sv
module smii_rx_status_hold
  import smii_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               seg_vld,
  input  logic [SEG_LEN-1:0] seg_word,
  output logic               carrier,
  output rx_status_t         status
);
  logic mark_ok;

  assign mark_ok = (seg_word[SEG_LEN-1 -: 3] == ST_MARK) && !seg_word[DV_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      carrier <= 1'b0;
      status  <= '0;
    end else if (seg_vld) begin
      carrier <= seg_word[CRS_BIT];
      if (mark_ok)
        status <= rx_status_t'(seg_word[PAY_LO +: ST_W]);
    end
  end
endmodule

// File: rtl/smii_rx_deser.sv
module smii_rx_deser
  import smii_rx_pkg::*;
#(
  parameter int REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic              rx_line,
  input  logic              mode_fast,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_vld,
  output logic              rx_frame_end,
  output logic              carrier_sense,
  output logic              st_rx_err,
  output logic              st_speed_100,
  output logic              st_full_duplex,
  output logic              st_link_up,
  output logic              st_jabber
);
  logic               seg_vld;
  logic [SEG_LEN-1:0] seg_word;
  rx_status_t         status;

  smii_rx_seg_capture #(.SEG_LEN(SEG_LEN)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (sync_in),
    .rx_line  (rx_line),
    .seg_vld  (seg_vld),
    .seg_word (seg_word)
  );

  smii_rx_rate_gate #(.REPEAT(REPEAT), .BYTE_W(BYTE_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .seg_vld   (seg_vld),
    .seg_dv    (seg_word[DV_BIT]),
    .payload   (seg_word[PAY_LO +: BYTE_W]),
    .mode_fast (mode_fast),
    .byte_out  (rx_byte),
    .byte_vld  (rx_byte_vld),
    .frame_end (rx_frame_end)
  );

  smii_rx_status_hold u_stat (
    .clk      (clk),
    .rst      (rst),
    .seg_vld  (seg_vld),
    .seg_word (seg_word),
    .carrier  (carrier_sense),
    .status   (status)
  );

  assign st_rx_err      = status.rx_err;
  assign st_speed_100   = status.speed;
  assign st_full_duplex = status.duplex;
  assign st_link_up     = status.link;
  assign st_jabber      = status.jabber;
endmodule

// File: rtl/smii_rx_deser_chk.sv
module smii_rx_deser_chk #(
  parameter int REPEAT = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       mode_fast,
  input logic       seg_vld,
  input logic       seg_dv,
  input logic       rx_byte_vld,
  input logic       rx_frame_end,
  input logic       carrier_sense,
  input logic [4:0] st_bits
);
  localparam int SC_W = $clog2(REPEAT + 1) + 1;

  logic [SC_W-1:0] segs_since;
  logic            armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      segs_since <= '0;
      armed      <= 1'b0;
    end else if (rx_frame_end) begin
      armed <= 1'b0;
    end else if (rx_byte_vld) begin
      armed      <= 1'b1;
      segs_since <= '0;
    end else if (seg_vld && (segs_since < SC_W'(REPEAT))) begin
      segs_since <= segs_since + 1'b1;
    end
  end

  // R4
  byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_byte_vld |=> !rx_byte_vld);

  // R5
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_frame_end |=> !rx_frame_end);

  // R5
  end_vs_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_frame_end && rx_byte_vld));

  // R2
  fast_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (seg_vld && seg_dv && mode_fast) |=> rx_byte_vld);

  // R3
  slow_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_byte_vld && armed && !mode_fast) |-> (segs_since >= SC_W'(REPEAT)));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(seg_vld) |-> $stable({carrier_sense, st_bits}));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rx_byte_vld && !rx_frame_end && !carrier_sense && st_bits == 5'd0));
endmodule

bind smii_rx_deser smii_rx_deser_chk #(.REPEAT(REPEAT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_fast     (mode_fast),
  .seg_vld       (seg_vld),
  .seg_dv        (seg_word[1]),
  .rx_byte_vld   (rx_byte_vld),
  .rx_frame_end  (rx_frame_end),
  .carrier_sense (carrier_sense),
  .st_bits       ({st_jabber, st_link_up, st_full_duplex, st_speed_100, st_rx_err})
);

// File: tb/smii_rx_deser_test.sv
module smii_rx_deser_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_in = 1'b0;
  logic       rx_line = 1'b0;
  logic       mode_fast = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_byte_vld, rx_frame_end, carrier_sense;
  logic       st_rx_err, st_speed_100, st_full_duplex, st_link_up, st_jabber;

  int checks = 0;
  int errors = 0;
  int ends_seen = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic prev_vld = 1'b0;

  always #2 clk = ~clk;

  smii_rx_deser uut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .rx_line(rx_line),
    .mode_fast(mode_fast), .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld),
    .rx_frame_end(rx_frame_end), .carrier_sense(carrier_sense),
    .st_rx_err(st_rx_err), .st_speed_100(st_speed_100),
    .st_full_duplex(st_full_duplex), .st_link_up(st_link_up),
    .st_jabber(st_jabber)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Segment word: bit0 carrier, bit1 data valid, bits 9:2 payload LSB first.
  task automatic send_seg(input logic crs, input logic dv, input logic [7:0] pl);
    logic [9:0] w;
    w = {pl, dv, crs};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sync_in = (i == 0);
      rx_line = w[i];
    end
  endtask

  // Status payload: err, speed, duplex, link, jabber, then marker bits.
  task automatic send_status(input logic crs, input logic [4:0] st, input logic [2:0] mark);
    send_seg(crs, 1'b0, {mark, st});
  endtask

  task automatic gap();
    repeat (3) begin
      @(negedge clk);
      sync_in = 1'b0;
      rx_line = 1'b0;
    end
  endtask

  task automatic check_status(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {st_jabber, st_link_up, st_full_duplex, st_speed_100, st_rx_err};
    check(act == exp, req, act, exp);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_byte_vld) begin
        check(!prev_vld, "R4 strobe width", 1, 0);
        if (exp_q.size() == 0)
          check(1'b0, "R2/R3 unexpected byte", rx_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rx_byte == e, "R2/R3 byte value", rx_byte, e);
        end
      end
      if (rx_frame_end) begin
        ends_seen++;
        check(!rx_byte_vld, "R5 end with byte", 1, 0);
      end
    end
    prev_vld = rx_byte_vld;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] fast_bytes[5];
    logic [7:0] slow_bytes[3];
    fast_bytes = '{8'h5A, 8'hA3, 8'h01, 8'hFF, 8'hB5};
    slow_bytes = '{8'h3C, 8'hC5, 8'h81};

    repeat (5) @(negedge clk);
    // R8 reset state
    check(!rx_byte_vld && !rx_frame_end, "R8 strobes in reset", rx_byte_vld, 0);
    check(!carrier_sense, "R8 carrier in reset", carrier_sense, 0);
    check_status("R8 status in reset", 5'd0);
    rst = 1'b0;

    // R6 valid status segment, R1 carrier from bit 1
    send_status(1'b1, 5'b01011, 3'b101);
    gap();
    check_status("R6 status load", 5'b01011);
    check(carrier_sense == 1'b1, "R1 carrier set", carrier_sense, 1);

    // R7 bad marker leaves status, R1 carrier still follows
    send_status(1'b0, 5'b10100, 3'b111);
    gap();
    check_status("R7 bad marker ignored", 5'b01011);
    check(carrier_sense == 1'b0, "R1 carrier clear", carrier_sense, 0);

    // R2 fast frame, data bytes shaped like status must not load status
    mode_fast = 1'b1;
    send_status(1'b0, 5'b00110, 3'b000);
    foreach (fast_bytes[i]) begin
      exp_q.push_back(fast_bytes[i]);
      send_seg(1'b1, 1'b1, fast_bytes[i]);
    end
    send_status(1'b0, 5'b11111, 3'b011);
    gap();
    check(exp_q.size() == 0, "R2 all fast bytes seen", exp_q.size(), 0);
    check(ends_seen == 1, "R5 one frame end", ends_seen, 1);
    check_status("R7 data segments ignored", 5'b01011);

    // R3 slow frame: only first of each ten repeats is taken
    mode_fast = 1'b0;
    send_status(1'b0, 5'b00000, 3'b001);
    foreach (slow_bytes[i]) begin
      exp_q.push_back(slow_bytes[i]);
      send_seg(1'b1, 1'b1, slow_bytes[i]);
      for (int k = 1; k < 10; k++)
        send_seg(1'b1, 1'b1, ~slow_bytes[i]);
    end
    send_status(1'b0, 5'b10001, 3'b101);
    gap();
    check(exp_q.size() == 0, "R3 slow bytes seen", exp_q.size(), 0);
    check(ends_seen == 2, "R5 second frame end", ends_seen, 2);
    check_status("R6 status after slow frame", 5'b10001);

    // R3 short slow frame of three segments yields one byte
    exp_q.push_back(8'h77);
    send_seg(1'b1, 1'b1, 8'h77);
    send_seg(1'b1, 1'b1, 8'h11);
    send_seg(1'b1, 1'b1, 8'h22);
    send_status(1'b0, 5'b11111, 3'b101);
    gap();
    check(exp_q.size() == 0, "R3 short frame one byte", exp_q.size(), 0);
    check_status("R6 all fields set", 5'b11111);

    // R8 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_status("R8 status cleared", 5'd0);
    check(!carrier_sense, "R8 carrier cleared", carrier_sense, 0);
    rst = 1'b0;
    send_status(1'b1, 5'b00100, 3'b101);
    gap();
    check_status("R6 status after reset", 5'b00100);

    finished = 1;
    summary();
    $finish;
  end
endmodule